// File: doc/BRIEF.md
# SRAM Block Security Filter

This block sits between a bus master port and an embedded SRAM. It checks every transaction against security and privilege attributes held separately for each 256-byte block of the SRAM. Each transaction carries a secure flag and a privileged flag. A transaction is forwarded to the SRAM only when both flags satisfy the target block's settings. A denied transaction never reaches the SRAM. It is answered with an error response and all-zero read data.

Every violation raises a sticky interrupt. The first violation is recorded: its address, its direction, its attributes, and whether it came from the configuration port. Later violations do not overwrite this record until software clears it with a secure write. The attribute bitmaps are written through a small configuration port, and only secure, privileged writes may change them.

Top module: `sram_block_guard`

## Requirements
- R1: The block index of a transaction is `req_addr_i[AW-1:8]`, where AW is the SRAM address width. Bytes 0x000–0x0FF form block 0, bytes 0x100–0x1FF form block 1, and so on.
- R2: A nonsecure transaction (`req_secure_i`=0) to a block whose secure bit is 1 is denied. A secure transaction is never denied because of the secure bit.
- R3: An unprivileged transaction (`req_priv_i`=0) to a block whose privilege bit is 1 is denied. A privileged transaction is never denied because of the privilege bit.
- R4: An allowed transaction appears on `mem_*` in the same cycle with its address, direction and write data unchanged. A denied transaction keeps `mem_valid_o` low, so a denied write leaves memory contents unchanged.
- R5: One cycle after a request, `rsp_valid_o` is 1. An allowed read returns `mem_rdata_i`, since the SRAM has one cycle of read latency. A denied transaction sets `rsp_err_o`=1 with `rsp_rdata_o`=0.
- R6: One cycle after a violation, `irq_o` is 1. If no violation was already pending, the fault outputs capture the address, write flag, secure flag, privilege flag and source (`fault_cfg_o`=1 for the configuration port). While a violation is pending, the record is held.
- R7: `irq_o` stays high until a configuration write with `cfg_secure_i`=1, index 2·NW and `cfg_wdata_i[0]`=1 clears it in the next cycle. The privilege flag does not matter for this write. A clear write that is not secure has no effect. If a new violation arrives in the same cycle as the clear, `irq_o` stays high and that violation is recorded.
- R8: Configuration index k < NW holds the secure bits of blocks 32k..32k+31, and index NW+k holds their privilege bits. Bit j maps to block 32k+j, and a bit value of 1 means secure or privileged. With the default size, NW=2. A write takes effect from the next cycle.
- R9: A write to a bitmap index that is not both secure and privileged is ignored and counts as a violation. For such a violation, `fault_addr_o` holds the configuration index. If a bus violation occurs in the same cycle, the bus violation is the one recorded.
- R10: After reset, all blocks are nonsecure and unprivileged, and `irq_o` and `rsp_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Transaction request |
| req_addr_i | input | AW | Byte offset into the SRAM |
| req_write_i | input | 1 | 1 = write |
| req_wdata_i | input | DW | Write data |
| req_secure_i | input | 1 | Transaction is secure |
| req_priv_i | input | 1 | Transaction is privileged |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_err_o | output | 1 | Transaction was denied |
| rsp_rdata_o | output | DW | Read data, zero when denied |
| mem_valid_o | output | 1 | Forwarded request to the SRAM |
| mem_addr_o | output | AW | Forwarded address |
| mem_write_o | output | 1 | Forwarded direction |
| mem_wdata_o | output | DW | Forwarded write data |
| mem_rdata_i | input | DW | SRAM read data, one cycle after the request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | CAW | Configuration register index |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_secure_i | input | 1 | Configuration write is secure |
| cfg_priv_i | input | 1 | Configuration write is privileged |
| irq_o | output | 1 | Sticky illegal-access interrupt |
| fault_addr_o | output | AW | Captured fault address or configuration index |
| fault_write_o | output | 1 | Captured write flag |
| fault_secure_o | output | 1 | Captured secure flag |
| fault_priv_o | output | 1 | Captured privilege flag |
| fault_cfg_o | output | 1 | Fault came from the configuration port |

## Verification
The forwarding decision on `mem_valid_o` is combinational, so the bench samples it in the same cycle as the request, after inputs settle. The response, the interrupt and the fault record all come one register stage later. The bench releases the request on the following falling edge and samples them there. Bitmap writes take effect on the next edge, so each test issues its configuration write one cycle before the access it affects. Writes that should be ignored are proven by a later access that is still denied or still allowed.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int BLK_SHIFT = 8;
  localparam int MAP_W     = 32;

  typedef enum logic [1:0] {
    CFG_SEC  = 2'd0,
    CFG_PRIV = 2'd1,
    CFG_CLR  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/sbg_attr_regs.sv
module sbg_attr_regs
  import sbg_pkg::*;
#(
  parameter int NBLK = 64,
  parameter int NW   = (NBLK + MAP_W - 1) / MAP_W,
  parameter int CAW  = $clog2(2 * NW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CAW-1:0]   cfg_idx_i,
  input  logic [MAP_W-1:0] cfg_wdata_i,
  input  logic             cfg_secure_i,
  input  logic             cfg_priv_i,
  output logic [NBLK-1:0]  sec_map_o,
  output logic [NBLK-1:0]  priv_map_o,
  output logic             cfg_viol_o,
  output logic             clr_o
);
  localparam int FLAT_W = NW * MAP_W;

  cfg_kind_e         kind;
  logic              attr_wr, cfg_ok;
  logic [FLAT_W-1:0] sec_flat, priv_flat;

  always_comb begin
    if (cfg_idx_i < CAW'(NW))            kind = CFG_SEC;
    else if (cfg_idx_i < CAW'(2 * NW))   kind = CFG_PRIV;
    else if (cfg_idx_i == CAW'(2 * NW))  kind = CFG_CLR;
    else                                 kind = CFG_NONE;
  end

  assign cfg_ok     = cfg_secure_i && cfg_priv_i;
  assign attr_wr    = cfg_we_i && (kind == CFG_SEC || kind == CFG_PRIV);
  assign cfg_viol_o = attr_wr && !cfg_ok;
  assign clr_o      = cfg_we_i && (kind == CFG_CLR) && cfg_secure_i && cfg_wdata_i[0];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [MAP_W-1:0] sec_q, priv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sec_q  <= '0;
        priv_q <= '0;
      end else if (attr_wr && cfg_ok) begin
        if (cfg_idx_i == CAW'(w))      sec_q  <= cfg_wdata_i;
        if (cfg_idx_i == CAW'(NW + w)) priv_q <= cfg_wdata_i;
      end
    end
    assign sec_flat[w*MAP_W +: MAP_W]  = sec_q;
    assign priv_flat[w*MAP_W +: MAP_W] = priv_q;
  end

  assign sec_map_o  = sec_flat[NBLK-1:0];
  assign priv_map_o = priv_flat[NBLK-1:0];
endmodule

// File: rtl/sbg_check.sv
module sbg_check #(
  parameter int NBLK = 64,
  parameter int BIW  = $clog2(NBLK)
) (
  input  logic            req_valid_i,
  input  logic [BIW-1:0]  blk_idx_i,
  input  logic            req_secure_i,
  input  logic            req_priv_i,
  input  logic [NBLK-1:0] sec_map_i,
  input  logic [NBLK-1:0] priv_map_i,
  output logic            allow_o,
  output logic            viol_o
);
  logic blk_sec, blk_priv;

  assign blk_sec  = sec_map_i[blk_idx_i];
  assign blk_priv = priv_map_i[blk_idx_i];
  // secure may touch nonsecure, privileged may touch unprivileged; not the reverse
  assign allow_o  = !(blk_sec && !req_secure_i) && !(blk_priv && !req_priv_i);
  assign viol_o   = req_valid_i && !allow_o;
endmodule

// File: rtl/sbg_fault_log.sv
module sbg_fault_log #(
  parameter int AW  = 14,
  parameter int CAW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_viol_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic           req_write_i,
  input  logic           req_secure_i,
  input  logic           req_priv_i,
  input  logic           cfg_viol_i,
  input  logic [CAW-1:0] cfg_idx_i,
  input  logic           cfg_secure_i,
  input  logic           cfg_priv_i,
  input  logic           clr_i,
  output logic           irq_o,
  output logic [AW-1:0]  fault_addr_o,
  output logic           fault_write_o,
  output logic           fault_secure_o,
  output logic           fault_priv_o,
  output logic           fault_cfg_o
);
  logic new_viol, capture;

  assign new_viol = req_viol_i || cfg_viol_i;
  assign capture  = new_viol && (!irq_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o          <= 1'b0;
      fault_addr_o   <= '0;
      fault_write_o  <= 1'b0;
      fault_secure_o <= 1'b0;
      fault_priv_o   <= 1'b0;
      fault_cfg_o    <= 1'b0;
    end else begin
      if (new_viol)   irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
      if (capture) begin
        if (req_viol_i) begin
          fault_addr_o   <= req_addr_i;
          fault_write_o  <= req_write_i;
          fault_secure_o <= req_secure_i;
          fault_priv_o   <= req_priv_i;
          fault_cfg_o    <= 1'b0;
        end else begin
          fault_addr_o   <= AW'(cfg_idx_i);
          fault_write_o  <= 1'b1;
          fault_secure_o <= cfg_secure_i;
          fault_priv_o   <= cfg_priv_i;
          fault_cfg_o    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sram_block_guard.sv
module sram_block_guard
  import sbg_pkg::*;
#(
  parameter int SRAM_BYTES = 16384,
  parameter int DW         = 32,
  localparam int AW        = $clog2(SRAM_BYTES),
  localparam int NBLK      = SRAM_BYTES >> BLK_SHIFT,
  localparam int NW        = (NBLK + MAP_W - 1) / MAP_W,
  localparam int CAW       = $clog2(2 * NW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             req_write_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             req_secure_i,
  input  logic             req_priv_i,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [DW-1:0]    rsp_rdata_o,
  output logic             mem_valid_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_write_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             cfg_we_i,
  input  logic [CAW-1:0]   cfg_idx_i,
  input  logic [MAP_W-1:0] cfg_wdata_i,
  input  logic             cfg_secure_i,
  input  logic             cfg_priv_i,
  output logic             irq_o,
  output logic [AW-1:0]    fault_addr_o,
  output logic             fault_write_o,
  output logic             fault_secure_o,
  output logic             fault_priv_o,
  output logic             fault_cfg_o
);
  localparam int BIW = AW - BLK_SHIFT;

  logic [NBLK-1:0] sec_map, priv_map;
  logic            cfg_viol, clr, allow, req_viol;
  logic            rsp_valid_q, rsp_err_q, rsp_wr_q;

  sbg_attr_regs #(.NBLK(NBLK), .NW(NW), .CAW(CAW)) u_attr (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_idx_i, .cfg_wdata_i, .cfg_secure_i, .cfg_priv_i,
    .sec_map_o(sec_map), .priv_map_o(priv_map),
    .cfg_viol_o(cfg_viol), .clr_o(clr)
  );

  sbg_check #(.NBLK(NBLK), .BIW(BIW)) u_check (
    .req_valid_i,
    .blk_idx_i(req_addr_i[AW-1:BLK_SHIFT]),
    .req_secure_i, .req_priv_i,
    .sec_map_i(sec_map), .priv_map_i(priv_map),
    .allow_o(allow), .viol_o(req_viol)
  );

  sbg_fault_log #(.AW(AW), .CAW(CAW)) u_log (
    .clk_i, .rst_ni,
    .req_viol_i(req_viol), .req_addr_i, .req_write_i, .req_secure_i, .req_priv_i,
    .cfg_viol_i(cfg_viol), .cfg_idx_i, .cfg_secure_i, .cfg_priv_i,
    .clr_i(clr),
    .irq_o, .fault_addr_o, .fault_write_o, .fault_secure_o, .fault_priv_o, .fault_cfg_o
  );

  assign mem_valid_o = req_valid_i && allow;
  assign mem_addr_o  = req_addr_i;
  assign mem_write_o = req_write_i;
  assign mem_wdata_o = req_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_wr_q    <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_viol;
      rsp_wr_q    <= req_write_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = (rsp_valid_q && !rsp_err_q && !rsp_wr_q) ? mem_rdata_i : '0;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int SRAM_BYTES = 16384,
  parameter int DW         = 32,
  parameter int AW         = 14,
  parameter int NBLK       = 64,
  parameter int NW         = 2,
  parameter int CAW        = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [AW-1:0]   req_addr_i,
  input logic            req_secure_i,
  input logic            req_priv_i,
  input logic            rsp_valid_o,
  input logic            rsp_err_o,
  input logic [DW-1:0]   rsp_rdata_o,
  input logic            mem_valid_o,
  input logic            cfg_we_i,
  input logic [CAW-1:0]  cfg_idx_i,
  input logic            cfg_wdata_b0,
  input logic            cfg_secure_i,
  input logic            cfg_priv_i,
  input logic            irq_o,
  input logic [AW-1:0]   fault_addr_o,
  input logic [NBLK-1:0] sec_map,
  input logic [NBLK-1:0] priv_map
);
  logic clr_cmd, blk_sec, blk_priv, cfg_denied;

  assign clr_cmd    = cfg_we_i && cfg_secure_i && cfg_wdata_b0 && (cfg_idx_i == CAW'(2 * NW));
  assign blk_sec    = sec_map[req_addr_i[AW-1:8]];
  assign blk_priv   = priv_map[req_addr_i[AW-1:8]];
  assign cfg_denied = cfg_we_i && (cfg_idx_i < CAW'(2 * NW)) && !(cfg_secure_i && cfg_priv_i);

  a_r2_ns_to_secure_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_secure_i && blk_sec |-> !mem_valid_o);
  a_r3_unpriv_to_priv_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_priv_i && blk_priv |-> !mem_valid_o);
  a_r5_resp_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r5_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o && rsp_rdata_o == '0);
  a_r6_irq_on_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !mem_valid_o |=> irq_o);
  a_r6_record_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(irq_o) && !$past(clr_cmd) |-> $stable(fault_addr_o));
  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_cmd |=> irq_o);
  a_r9_denied_cfg_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_denied |=> irq_o && $stable(sec_map) && $stable(priv_map));
endmodule

bind sram_block_guard sbg_checker #(
  .SRAM_BYTES(SRAM_BYTES), .DW(DW), .AW(AW), .NBLK(NBLK), .NW(NW), .CAW(CAW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_secure_i(req_secure_i), .req_priv_i(req_priv_i),
  .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
  .mem_valid_o(mem_valid_o),
  .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_wdata_b0(cfg_wdata_i[0]),
  .cfg_secure_i(cfg_secure_i), .cfg_priv_i(cfg_priv_i),
  .irq_o(irq_o), .fault_addr_o(fault_addr_o),
  .sec_map(sec_map), .priv_map(priv_map)
);

// File: tb/sram_block_guard_tb.sv
module sram_block_guard_tb;
  localparam int AW  = 14;
  localparam int DW  = 32;
  localparam int CAW = 3;
  localparam logic [CAW-1:0] CLR_IDX = 3'd4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid_i = 0, req_write_i = 0, req_secure_i = 0, req_priv_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          rsp_valid_o, rsp_err_o, mem_valid_o, mem_write_o;
  logic [DW-1:0] rsp_rdata_o, mem_wdata_o, mem_rdata_i;
  logic [AW-1:0] mem_addr_o, fault_addr_o;
  logic          cfg_we_i = 0, cfg_secure_i = 0, cfg_priv_i = 0;
  logic [CAW-1:0] cfg_idx_i = '0;
  logic [31:0]   cfg_wdata_i = '0;
  logic          irq_o, fault_write_o, fault_secure_o, fault_priv_o, fault_cfg_o;

  int checks = 0, errors = 0;
  bit done = 0;

  sram_block_guard u_dut (
    .clk_i(clk), .rst_ni,
    .req_valid_i, .req_addr_i, .req_write_i, .req_wdata_i, .req_secure_i, .req_priv_i,
    .rsp_valid_o, .rsp_err_o, .rsp_rdata_o,
    .mem_valid_o, .mem_addr_o, .mem_write_o, .mem_wdata_o, .mem_rdata_i,
    .cfg_we_i, .cfg_idx_i, .cfg_wdata_i, .cfg_secure_i, .cfg_priv_i,
    .irq_o, .fault_addr_o, .fault_write_o, .fault_secure_o, .fault_priv_o, .fault_cfg_o
  );

  logic [DW-1:0] sram [4096];
  logic [DW-1:0] rd_q = '0;
  initial for (int i = 0; i < 4096; i++) sram[i] = '0;
  always @(posedge clk) begin
    if (mem_valid_o) begin
      if (mem_write_o) sram[mem_addr_o[AW-1:2]] <= mem_wdata_o;
      else             rd_q <= sram[mem_addr_o[AW-1:2]];
    end
  end
  assign mem_rdata_i = rd_q;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one request; returns forward flag seen in request cycle, and response
  task automatic access(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] d,
                        input logic s, input logic p,
                        output logic fwd, output logic err, output logic [DW-1:0] rd);
    req_valid_i = 1; req_addr_i = a; req_write_i = wr; req_wdata_i = d;
    req_secure_i = s; req_priv_i = p;
    #1 fwd = mem_valid_o;
    @(negedge clk);
    req_valid_i = 0;
    chk("R5 rsp_valid", 64'(rsp_valid_o), 64'd1);
    err = rsp_err_o; rd = rsp_rdata_o;
  endtask

  task automatic cfg(input logic [CAW-1:0] idx, input logic [31:0] d, input logic s, input logic p);
    cfg_we_i = 1; cfg_idx_i = idx; cfg_wdata_i = d; cfg_secure_i = s; cfg_priv_i = p;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic t_reset;
    chk("R10 irq after reset", 64'(irq_o), 0);
    chk("R10 rsp_valid after reset", 64'(rsp_valid_o), 0);
  endtask

  task automatic t_legal_default;
    logic f, e; logic [DW-1:0] r;
    access(14'h104, 1, 32'hCAFE_0104, 0, 0, f, e, r);
    chk("R4 write forwarded", 64'(f), 1);
    chk("R5 write no err", 64'(e), 0);
    access(14'h104, 0, 0, 0, 0, f, e, r);
    chk("R5 read data", 64'(r), 64'hCAFE_0104);
    chk("R10 no irq on legal", 64'(irq_o), 0);
  endtask

  task automatic t_secure_block;
    logic f, e; logic [DW-1:0] r;
    cfg(3'd0, 32'h0000_0002, 1, 1);          // block 1 secure
    access(14'h1FC, 0, 0, 0, 1, f, e, r);
    chk("R2 ns blocked fwd", 64'(f), 0);
    chk("R2 ns blocked err", 64'(e), 1);
    chk("R5 blocked rdata zero", 64'(r), 0);
    chk("R6 irq set", 64'(irq_o), 1);
    chk("R6 fault addr", 64'(fault_addr_o), 64'h1FC);
    chk("R6 fault secure flag", 64'(fault_secure_o), 0);
    chk("R6 fault cfg flag", 64'(fault_cfg_o), 0);
    access(14'h200, 0, 0, 0, 1, f, e, r);
    chk("R1 block2 allowed", 64'(e), 0);
    access(14'h0FC, 0, 0, 0, 1, f, e, r);
    chk("R1 block0 allowed", 64'(e), 0);
    access(14'h104, 1, 32'hDEAD_BEEF, 0, 1, f, e, r);
    chk("R4 blocked write no fwd", 64'(f), 0);
    chk("R6 record held", 64'(fault_addr_o), 64'h1FC);
    chk("R6 write flag held", 64'(fault_write_o), 0);
    access(14'h104, 0, 0, 1, 0, f, e, r);
    chk("R2 secure to secure ok", 64'(e), 0);
    chk("R4 memory unchanged", 64'(r), 64'hCAFE_0104);
  endtask

  task automatic t_clear;
    cfg(CLR_IDX, 32'h1, 0, 1);
    chk("R7 ns clear ignored", 64'(irq_o), 1);
    cfg(CLR_IDX, 32'h1, 1, 0);
    chk("R7 secure clear", 64'(irq_o), 0);
  endtask

  task automatic t_priv_block;
    logic f, e; logic [DW-1:0] r;
    cfg(3'd3, 32'h0000_0001, 1, 1);          // block 32 privileged
    access(14'h2000, 1, 32'h5, 1, 0, f, e, r);
    chk("R3 unpriv blocked", 64'(e), 1);
    chk("R3 fault priv flag", 64'(fault_priv_o), 0);
    chk("R3 fault write flag", 64'(fault_write_o), 1);
    access(14'h2000, 0, 0, 0, 1, f, e, r);
    chk("R3 priv ns allowed", 64'(e), 0);
    t_clear();
  endtask

  task automatic t_cfg_denied;
    logic f, e; logic [DW-1:0] r;
    cfg(3'd0, 32'h0, 0, 1);
    chk("R9 denied cfg irq", 64'(irq_o), 1);
    chk("R9 fault cfg flag", 64'(fault_cfg_o), 1);
    chk("R9 fault index", 64'(fault_addr_o), 0);
    t_clear();
    cfg(3'd0, 32'h0, 1, 0);
    chk("R9 secure unpriv cfg irq", 64'(irq_o), 1);
    t_clear();
    access(14'h100, 0, 0, 0, 1, f, e, r);
    chk("R9 map unchanged", 64'(e), 1);
  endtask

  task automatic t_clear_and_viol;
    logic f, e; logic [DW-1:0] r;
    cfg_we_i = 1; cfg_idx_i = CLR_IDX; cfg_wdata_i = 1; cfg_secure_i = 1; cfg_priv_i = 1;
    access(14'h180, 0, 0, 0, 0, f, e, r);
    cfg_we_i = 0;
    chk("R7 clear+viol irq stays", 64'(irq_o), 1);
    chk("R7 clear+viol new record", 64'(fault_addr_o), 64'h180);
    t_clear();
  endtask

  task automatic t_second_word;
    logic f, e; logic [DW-1:0] r;
    cfg(3'd1, 32'h8000_0000, 1, 1);          // block 63 secure
    access(14'h3FFC, 0, 0, 0, 1, f, e, r);
    chk("R8 word1 bit31 blocks", 64'(e), 1);
    access(14'h3EFC, 0, 0, 0, 1, f, e, r);
    chk("R8 block62 allowed", 64'(e), 0);
    t_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_legal_default();
    t_secure_block();
    t_clear();
    t_priv_block();
    t_cfg_denied();
    t_clear_and_viol();
    t_second_word();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule